// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher with Shared Fetch-and-Add

This block hands out virtual thread numbers to a fixed set of worker lanes for one parallel section at a time. A master raises a spawn request carrying an inclusive upper thread number. When the block is idle it accepts the request, latches the bound and shares it with every lane. Each lane then claims thread numbers one at a time and offers each claimed number to the worker it serves.

Lane `i` (counting from 0) starts with thread number `i+1` and claims no counter value for it. Every later number comes from one shared fetch-and-add counter that any number of lanes may hit in the same cycle. A lane whose claimed number is above the bound retires. When every lane has retired, the block reports the join and is ready for the next spawn. No lane ever waits on another lane. Each one waits only for its own worker to finish a thread, or for its own claim result, which comes back one cycle after the request.

Top module: `lane_spawn_dispatch`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `spawn_accept`, `join_done` and every bit of `start_valid` are 0.
- R2: A `spawn_req` sampled while `busy` is 0 is accepted. In the next cycle `spawn_accept` is 1 for one cycle and `busy` is 1. Each lane `i` with `i+1 <= spawn_bound` raises `start_valid[i]` in that same cycle, with `start_id` lane field `i` (bits `i*ID_W` upward) equal to `i+1`.
- R3: A lane with `i+1 > bound` never raises `start_valid` during that spawn. With a bound of 0, `join_done` rises two cycles after the accepted request.
- R4: A `done[i]` pulse while lane `i` is running its thread makes the lane claim the next counter value. If that value is at most the bound, `start_valid[i]` rises in the next cycle carrying it. Otherwise the lane retires.
- R5: The shared counter starts at `NUM_LANES+1` on each spawn. Lanes that claim in the same cycle receive consecutive values in ascending lane order.
- R6: Over one spawn, every thread number from 1 to the bound is offered and accepted exactly once, and no number above the bound is ever offered.
- R7: `join_done` is a one-cycle pulse. It rises in the cycle after the last lane retires, and `busy` falls in the same cycle. It is never 1 while a lane still holds or runs a thread.
- R8: A `spawn_req` sampled while `busy` is 1 is ignored. `spawn_accept` stays 0, and the bound and the lanes' thread numbers are unchanged.
- R9: A `done[i]` pulse while lane `i` is not running a thread has no effect.
- R10: While `start_valid[i]` is 1 and `start_ready[i]` is 0, the lane keeps `start_valid[i]` at 1 and its `start_id` field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spawn_req | input | 1 | Master asks to open a parallel section |
| spawn_bound | input | ID_W | Inclusive highest thread number for the section |
| spawn_accept | output | 1 | One-cycle pulse: the request was taken |
| busy | output | 1 | A section is open |
| start_valid | output | NUM_LANES | Lane offers a thread number to its worker |
| start_ready | input | NUM_LANES | Worker takes the offered thread |
| start_id | output | NUM_LANES*ID_W | Offered thread number, one ID_W field per lane |
| done | input | NUM_LANES | Worker pulses when its current thread has finished |
| join_done | output | 1 | One-cycle pulse: every lane has retired |

## Verification
A wrong value in the shared counter shows up at the very next offer that follows a claim. The offer carries a repeated or skipped thread number in the cycle after the `done` pulse, so comparing against a reference model every cycle catches it at once. A stuck or misrouted lane state shows either as a `start_valid` that differs from the model within one cycle, or as a late or early `join_done`. The end-of-spawn tally of accepted thread numbers adds a second, order-free view: any number that is lost, duplicated or above the bound appears there.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [1:0] {
    LN_IDLE    = 2'd0,
    LN_OFFER   = 2'd1,
    LN_RUN     = 2'd2,
    LN_RETIRED = 2'd3
  } lane_state_t;
endpackage

// File: rtl/claim_counter.sv
// Shared fetch-and-add: any subset of lanes may claim in one cycle.
module claim_counter #(
  parameter int N  = 8,
  parameter int CW = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CW-1:0]        load_val,
  input  logic [N-1:0]         req,
  output logic [N-1:0][CW-1:0] grant
);
  logic [CW-1:0] count;
  logic [CW-1:0] next_count;

  // lower lane index is served first
  always_comb begin
    next_count = count;
    for (int i = 0; i < N; i++) begin
      grant[i]   = next_count;
      next_count = next_count + CW'(req[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else           count <= next_count;
  end

  // R5: between spawns the counter only moves forward
  a_r5_never_back: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> (count >= $past(count)));
endmodule

// File: rtl/dispatch_lane.sv
module dispatch_lane
  import dispatch_pkg::*;
#(
  parameter int IDX  = 0,
  parameter int ID_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spawn_go,
  input  logic [ID_W-1:0] go_bound,
  input  logic [ID_W-1:0] bound,
  input  logic          start_ready,
  input  logic          done,
  input  logic [ID_W:0] claim_val,
  output logic          claim_req,
  output logic          start_valid,
  output logic [ID_W-1:0] start_id,
  output logic          retired
);
  localparam int CW = ID_W + 1;
  localparam logic [CW-1:0] FIRST = CW'(IDX + 1);

  lane_state_t   state;
  logic [CW-1:0] id;

  assign claim_req   = (state == LN_RUN) && done;
  assign start_valid = (state == LN_OFFER);
  assign start_id    = id[ID_W-1:0];
  assign retired     = (state == LN_RETIRED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LN_IDLE;
      id    <= '0;
    end else if (spawn_go) begin
      if (FIRST <= {1'b0, go_bound}) begin
        state <= LN_OFFER;
        id    <= FIRST;
      end else begin
        state <= LN_RETIRED;
      end
    end else begin
      case (state)
        LN_OFFER: if (start_ready) state <= LN_RUN;
        LN_RUN: if (done) begin
          if (claim_val > {1'b0, bound}) begin
            state <= LN_RETIRED;
          end else begin
            state <= LN_OFFER;
            id    <= claim_val;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // R10: offer held stable under backpressure
  a_r10_hold_offer: assert property (@(posedge clk) disable iff (rst)
    (start_valid && !start_ready && !spawn_go) |=> (start_valid && $stable(start_id)));
  // R6: nothing outside 1..bound is ever offered
  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> (start_id != '0 && start_id <= bound));
  // R9: a done outside a running thread leaves the thread number alone
  a_r9_ignore_done: assert property (@(posedge clk) disable iff (rst)
    (state != LN_RUN && !spawn_go) |=> $stable(id));
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spawn_req,
  input  logic [ID_W-1:0] spawn_bound,
  input  logic            all_retired,
  output logic            spawn_go,
  output logic [ID_W-1:0] bound_q,
  output logic            active,
  output logic            spawn_accept,
  output logic            join_done
);
  assign spawn_go = spawn_req && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      bound_q      <= '0;
      spawn_accept <= 1'b0;
      join_done    <= 1'b0;
    end else begin
      spawn_accept <= spawn_go;
      join_done    <= 1'b0;
      if (spawn_go) begin
        active  <= 1'b1;
        bound_q <= spawn_bound;
      end else if (active && all_retired) begin
        active    <= 1'b0;
        join_done <= 1'b1;
      end
    end
  end

  // R7: join is a single pulse
  a_r7_join_pulse: assert property (@(posedge clk) disable iff (rst)
    join_done |=> !join_done);
  // R7: no join while any lane is still working
  a_r7_join_needs_retired: assert property (@(posedge clk) disable iff (rst)
    (active && !all_retired) |=> !join_done);
  // R8: no nested spawn
  a_r8_no_nest: assert property (@(posedge clk) disable iff (rst)
    (active && spawn_req) |=> (!spawn_accept && $stable(bound_q)));
endmodule

// File: rtl/lane_spawn_dispatch.sv
module lane_spawn_dispatch #(
  parameter int NUM_LANES = 8,
  parameter int ID_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      spawn_req,
  input  logic [ID_W-1:0]           spawn_bound,
  output logic                      spawn_accept,
  output logic                      busy,
  output logic [NUM_LANES-1:0]      start_valid,
  input  logic [NUM_LANES-1:0]      start_ready,
  output logic [NUM_LANES*ID_W-1:0] start_id,
  input  logic [NUM_LANES-1:0]      done,
  output logic                      join_done
);
  localparam int CW = ID_W + 1;
  localparam logic [CW-1:0] FA_START = CW'(NUM_LANES + 1);

  logic                         spawn_go;
  logic [ID_W-1:0]              bound_q;
  logic [NUM_LANES-1:0]         claim_req;
  logic [NUM_LANES-1:0]         retired;
  logic [NUM_LANES-1:0][CW-1:0] grant;

  dispatch_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .spawn_req(spawn_req), .spawn_bound(spawn_bound),
    .all_retired(&retired),
    .spawn_go(spawn_go), .bound_q(bound_q), .active(busy),
    .spawn_accept(spawn_accept), .join_done(join_done)
  );

  claim_counter #(.N(NUM_LANES), .CW(CW)) u_fa (
    .clk(clk), .rst(rst),
    .load(spawn_go), .load_val(FA_START),
    .req(claim_req), .grant(grant)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dispatch_lane #(.IDX(g), .ID_W(ID_W)) u_lane (
      .clk(clk), .rst(rst),
      .spawn_go(spawn_go), .go_bound(spawn_bound), .bound(bound_q),
      .start_ready(start_ready[g]), .done(done[g]),
      .claim_val(grant[g]), .claim_req(claim_req[g]),
      .start_valid(start_valid[g]), .start_id(start_id[g*ID_W +: ID_W]),
      .retired(retired[g])
    );
  end
endmodule

// File: tb/lane_spawn_dispatch_bench.sv
module lane_spawn_dispatch_bench;
  localparam int N = 8;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sreq = 1'b0;
  logic [W-1:0] sbound = '0;
  logic [N-1:0] rdy = '0;
  logic [N-1:0] dn = '0;
  logic s_acc, s_busy, s_join;
  logic [N-1:0] s_valid;
  logic [N*W-1:0] s_id;

  always #10 clk = ~clk;

  lane_spawn_dispatch #(.NUM_LANES(N), .ID_W(W)) u_lane_spawn_dispatch (
    .clk(clk), .rst(rst), .spawn_req(sreq), .spawn_bound(sbound),
    .spawn_accept(s_acc), .busy(s_busy), .start_valid(s_valid),
    .start_ready(rdy), .start_id(s_id), .done(dn), .join_done(s_join)
  );

  // reference model: 0 idle, 1 offer, 2 run, 3 retired
  int mst[N], mid[N], lat[N];
  int mnext, mbound, cycles;
  bit mactive, maccept, mjoin;
  int seen[512];
  int n_chk = 0, n_fail = 0;
  bit pv[N];
  int pid[N];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk(s_acc == maccept, "R2/R8 spawn_accept", int'(s_acc), int'(maccept));
    chk(s_busy == mactive, "R7 busy", int'(s_busy), int'(mactive));
    chk(s_join == mjoin, "R7 join_done", int'(s_join), int'(mjoin));
    for (int i = 0; i < N; i++) begin
      int got;
      got = int'(s_id[i*W +: W]);
      chk(s_valid[i] == (mst[i] == 1), "R3/R4/R9 start_valid", int'(s_valid[i]), int'(mst[i] == 1));
      if (mst[i] == 1) chk(got == mid[i], "R2/R4/R5 start_id", got, mid[i]);
      if (pv[i]) chk(s_valid[i] && got == pid[i], "R10 offer held", got, pid[i]);
    end
  endtask

  // one cycle: compare, apply inputs, advance the model to the next cycle
  task automatic cycle(bit req_in, int bnd, int rpct, int maxlat, bit noise);
    int k, v;
    bit all_ret;
    compare();
    sreq = req_in;
    sbound = W'(bnd);
    for (int i = 0; i < N; i++) begin
      rdy[i] = ($urandom_range(99) < rpct);
      dn[i] = 1'b0;
      if (mst[i] == 2) begin
        if (lat[i] == 0) dn[i] = 1'b1;
        else lat[i]--;
      end else if (noise && $urandom_range(3) == 0) dn[i] = 1'b1;
      pv[i] = (mst[i] == 1) && !rdy[i];
      pid[i] = mid[i];
    end
    all_ret = 1'b1;
    for (int i = 0; i < N; i++) if (mst[i] != 3) all_ret = 1'b0;
    mjoin = 1'b0;
    if (!mactive && req_in) begin
      maccept = 1'b1; mactive = 1'b1; mbound = bnd; mnext = N + 1;
      for (int i = 0; i < N; i++) begin
        if (i + 1 <= bnd) begin mst[i] = 1; mid[i] = i + 1; end
        else mst[i] = 3;
        pv[i] = 1'b0;
      end
    end else begin
      maccept = 1'b0;
      if (mactive && all_ret) begin mactive = 1'b0; mjoin = 1'b1; end
      k = 0;
      for (int i = 0; i < N; i++) begin
        if (mst[i] == 1 && rdy[i]) begin
          mst[i] = 2; lat[i] = $urandom_range(maxlat);
          if (mid[i] < 512) seen[mid[i]]++;
        end else if (mst[i] == 2 && dn[i]) begin
          v = mnext + k; k++;
          if (v > mbound) mst[i] = 3;
          else begin mst[i] = 1; mid[i] = v; end
        end
      end
      mnext += k;
    end
    cycles++;
    @(negedge clk);
  endtask

  task automatic run_spawn(int bnd, int rpct, int maxlat, bit noise, bit nest);
    int guard, starts;
    bit got_join;
    for (int j = 0; j < 512; j++) seen[j] = 0;
    cycle(1'b1, bnd, rpct, maxlat, noise);
    guard = 0;
    got_join = 1'b0;
    while (!got_join && guard < 20000) begin
      // R8: nested spawn attempts with a different bound while busy
      cycle(nest && mactive && $urandom_range(2) == 0, bnd + 7, rpct, maxlat, noise);
      if (mjoin) got_join = 1'b1;
      guard++;
    end
    chk(got_join, "watchdog R7 join reached", int'(got_join), 1);
    cycle(1'b0, 0, rpct, 0, noise);
    cycle(1'b0, 0, rpct, 0, noise);
    starts = 0;
    for (int j = 0; j < 512; j++) begin
      starts += seen[j];
      if (j >= 1 && j <= bnd) chk(seen[j] == 1, "R6 id started once", seen[j], 1);
    end
    chk(starts == bnd, "R6 total starts equal bound", starts, bnd);
  endtask

  initial begin
    cycles = 0;
    mactive = 0; maccept = 0; mjoin = 0; mnext = 0; mbound = 0;
    for (int i = 0; i < N; i++) begin mst[i] = 0; mid[i] = 0; lat[i] = 0; pv[i] = 0; pid[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!s_busy && !s_acc && !s_join && s_valid == '0, "R1 reset outputs", int'(s_valid), 0);
    rst = 1'b0;
    // R9: stray done pulses before any spawn
    for (int c = 0; c < 4; c++) cycle(1'b0, 0, 50, 0, 1'b1);
    run_spawn(20, 60, 4, 1'b1, 1'b1);   // R2 R4 R9 R10 mixed traffic
    run_spawn(0, 100, 0, 1'b0, 1'b0);   // R3 empty section
    run_spawn(3, 70, 3, 1'b1, 1'b1);    // R3 fewer threads than lanes
    run_spawn(N, 100, 2, 1'b0, 1'b0);   // exactly one thread per lane
    run_spawn(200, 100, 0, 1'b0, 1'b1); // R5 all lanes claim together
    run_spawn(57, 30, 6, 1'b1, 1'b1);   // R10 heavy backpressure
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule